// File: doc/BRIEF.md
# Card Capacity CSD Encoder

This block turns a storage size, given as a count of 512-byte sectors, into the four 32-bit words of a 128-bit card-specific-data response. Each word starts from a fixed template, and the capacity fields are ORed into it. The format depends on the size. If the size in bytes is above 2^31, the encoder selects the high-capacity format, which carries a single 22-bit block count. Otherwise it selects the standard format, which carries a 12-bit mantissa and a 3-bit exponent.

A one-cycle `start` pulse loads the sector count. The high-capacity result is ready after one more clock. The standard path needs extra clocks: it shifts the kilobyte count right by one bit per clock until the count is no larger than 4096. When the result is ready, `done` pulses for one cycle together with the response words, the format flag and an error code. These outputs then hold until the next run completes. A size that cannot be represented gives an error code and all-zero response words.

Top module: `csd_cap_encoder`

## Requirements
- R1: During and after reset, with no start accepted, `busy`, `done`, `hc_flag` and `err` are 0 and all four response words are 0.
- R2: The high-capacity format is selected, and `hc_flag` is 1 at `done`, exactly when the sector count exceeds 4194304 (more than 2^31 bytes). Otherwise `hc_flag` is 0.
- R3: High capacity: let m = floor(sectors / 1024) - 1. The result words are w3 = 0x400E0032, w2 = 0x5B590000 | m[21:16] in bits 5:0, w1 = 0x00007F80 | m[15:0] in bits 31:16, and w0 = 0x0A4040DF. `err` is 2'b00.
- R4: High capacity: if m is 2^22 or more, `err` is 2'b10 (too large) and all four words are 0.
- R5: Standard format: kb = floor(sectors / 2). Let n be the smallest count for which (kb >> n) <= 4096, with v = (kb >> n) - 1 and e = n - 2. The result words are w3 = 0x00260032, w2 = 0x5F5A8000 | v[11:2] in bits 9:0, w1 = 0x3EF84FFF | v[1:0] in bits 31:30 | e in bits 17:15, and w0 = 0x928040CB. `err` is 2'b00.
- R6: Standard format: n < 2 gives `err` = 2'b01 (too small), and e > 7 gives `err` = 2'b10. In both cases all four words are 0.
- R7: `done` is high for exactly one cycle. It rises 1 rising edge after the edge that samples `start` for high capacity, and n + 2 edges after it for standard. `busy` is high from the edge that accepts `start` until the edge that raises `done`.
- R8: A `start` while `busy` is high is ignored. The running operation finishes with its own result and timing.
- R9: The response words, `err` and `hc_flag` change only in the cycle where `done` is high. A `start` given in the same cycle as `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to encode `sector_count` |
| sector_count | input | 34 | Storage size in 512-byte sectors, sampled with `start` |
| busy | output | 1 | An encoding is in progress |
| done | output | 1 | One-cycle pulse: result outputs updated |
| hc_flag | output | 1 | 1 when the high-capacity format was chosen |
| err | output | 2 | 00 ok, 01 too small, 10 too large |
| resp_w0 | output | 32 | Response word 0 (bits 31:0) |
| resp_w1 | output | 32 | Response word 1 (bits 63:32) |
| resp_w2 | output | 32 | Response word 2 (bits 95:64) |
| resp_w3 | output | 32 | Response word 3 (bits 127:96) |

## Verification
A new `start` can arrive in the same cycle as the `done` pulse that ends the previous run. The bench provokes this by raising `start` with a different sector count at the sample point where it first sees `done`. It then checks two things: the completed result is intact in that `done` cycle, and the new run comes back with the latency and words the bench computes for it. The bench also puts a `start` into the middle of a long standard run. It confirms that the intruding request changes neither the result nor the latency.

// File: rtl/csd_cap_pkg.sv
package csd_cap_pkg;

  typedef enum logic [1:0] {
    CAP_OK        = 2'd0,
    CAP_TOO_SMALL = 2'd1,
    CAP_TOO_LARGE = 2'd2
  } cap_err_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_FIN   = 2'd2
  } enc_state_e;

  typedef struct packed {
    logic [31:0] w3;
    logic [31:0] w2;
    logic [31:0] w1;
    logic [31:0] w0;
  } csd_words_t;

  localparam logic [31:0] HC_T3 = 32'h400E0032;
  localparam logic [31:0] HC_T2 = 32'h5B590000;
  localparam logic [31:0] HC_T1 = 32'h00007F80;
  localparam logic [31:0] HC_T0 = 32'h0A4040DF;

  localparam logic [31:0] SD_T3 = 32'h00260032;
  localparam logic [31:0] SD_T2 = 32'h5F5A8000;
  localparam logic [31:0] SD_T1 = 32'h3EF84FFF;
  localparam logic [31:0] SD_T0 = 32'h928040CB;

  // high-capacity: 22-bit block field split across words 2 and 1
  function automatic csd_words_t hc_fill(input logic [21:0] m);
    csd_words_t r;
    r.w3 = HC_T3;
    r.w2 = HC_T2 | {26'd0, m[21:16]};
    r.w1 = HC_T1 | {m[15:0], 16'd0};
    r.w0 = HC_T0;
    return r;
  endfunction

  // standard: 12-bit mantissa split across words 2 and 1, exponent at bit 15
  function automatic csd_words_t sd_fill(input logic [11:0] v, input logic [2:0] e);
    csd_words_t r;
    r.w3 = SD_T3;
    r.w2 = SD_T2 | {22'd0, v[11:2]};
    r.w1 = SD_T1 | {v[1:0], 30'd0} | {14'd0, e, 15'd0};
    r.w0 = SD_T0;
    return r;
  endfunction

endpackage

// File: rtl/csd_range_shifter.sv
module csd_range_shifter #(
  parameter int KB_W     = 33,
  parameter int EXP_W    = 6,
  parameter int KB_LIMIT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [KB_W-1:0]  load_kb,
  input  logic             step_en,
  output logic [KB_W-1:0]  kb,
  output logic [EXP_W-1:0] exp_cnt,
  output logic             fits
);

  localparam logic [KB_W-1:0] LIMIT = KB_W'(KB_LIMIT);

  logic do_step;

  assign fits    = (kb <= LIMIT);
  assign do_step = step_en && !fits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kb      <= '0;
      exp_cnt <= '0;
    end else if (load) begin
      kb      <= load_kb;
      exp_cnt <= '0;
    end else if (do_step) begin
      kb      <= kb >> 1;
      exp_cnt <= exp_cnt + 1'b1;
    end
  end

  // R5: every shift taken raises the exponent by exactly one
  assert_exp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !fits && !load) |=> (exp_cnt == $past(exp_cnt) + EXP_W'(1)));

  // R5: a shift halves the value
  assert_kb_halves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !fits && !load) |=> (kb == ($past(kb) >> 1)));

endmodule

// File: rtl/csd_word_merge.sv
module csd_word_merge
  import csd_cap_pkg::*;
#(
  parameter int HB_W  = 24,
  parameter int KB_W  = 33,
  parameter int EXP_W = 6
) (
  input  logic             hc_sel,
  input  logic [HB_W-1:0]  blocks,
  input  logic [KB_W-1:0]  kb,
  input  logic [EXP_W-1:0] exp_cnt,
  output csd_words_t       words,
  output cap_err_e         err
);

  localparam int HC_FIELD_W = 22;
  localparam int MANT_W     = 12;

  logic [HB_W-1:0]  hc_m;
  logic             hc_ovf;
  logic [KB_W-1:0]  kb_m1;
  logic             mant_ovf;
  logic [EXP_W-1:0] exp_adj;
  logic             sd_small;
  logic             sd_large;

  assign hc_m     = blocks - HB_W'(1);
  assign hc_ovf   = |hc_m[HB_W-1:HC_FIELD_W];
  assign kb_m1    = kb - KB_W'(1);
  assign mant_ovf = |kb_m1[KB_W-1:MANT_W];
  assign exp_adj  = exp_cnt - EXP_W'(2);
  assign sd_small = (exp_cnt < EXP_W'(2));
  assign sd_large = (exp_adj > EXP_W'(7)) || mant_ovf;

  always_comb begin
    words = '0;
    err   = CAP_OK;
    if (hc_sel) begin
      if (hc_ovf) err = CAP_TOO_LARGE;
      else        words = hc_fill(hc_m[HC_FIELD_W-1:0]);
    end else begin
      if (sd_small)      err = CAP_TOO_SMALL;
      else if (sd_large) err = CAP_TOO_LARGE;
      else               words = sd_fill(kb_m1[MANT_W-1:0], exp_adj[2:0]);
    end
  end

endmodule

// File: rtl/csd_cap_encoder.sv
module csd_cap_encoder
  import csd_cap_pkg::*;
#(
  parameter int    SECT_W   = 34,
  parameter int    EXP_W    = 6,
  parameter int    KB_LIMIT = 4096,
  parameter longint HC_BYTES = 64'd2147483648
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SECT_W-1:0] sector_count,
  output logic              busy,
  output logic              done,
  output logic              hc_flag,
  output logic [1:0]        err,
  output logic [31:0]       resp_w0,
  output logic [31:0]       resp_w1,
  output logic [31:0]       resp_w2,
  output logic [31:0]       resp_w3
);

  localparam int KB_W = SECT_W - 1;
  localparam int HB_W = SECT_W - 10;
  localparam logic [SECT_W-1:0] HC_LIM = SECT_W'(HC_BYTES / 512);

  enc_state_e       st;
  logic             hc_r;
  logic [HB_W-1:0]  blocks_r;
  logic             done_r;
  logic             hc_flag_r;
  cap_err_e         err_r;
  csd_words_t       words_r;

  // named internal events
  logic             accept_start;
  logic             shift_phase;
  logic             finish_phase;
  logic             is_hc;
  logic [KB_W-1:0]  kb;
  logic [EXP_W-1:0] exp_cnt;
  logic             kb_fits;
  csd_words_t       merged;
  cap_err_e         merged_err;

  assign accept_start = (st == ST_IDLE) && start;
  assign shift_phase  = (st == ST_SHIFT);
  assign finish_phase = (st == ST_FIN);
  assign is_hc        = (sector_count > HC_LIM);

  csd_range_shifter #(
    .KB_W(KB_W), .EXP_W(EXP_W), .KB_LIMIT(KB_LIMIT)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_start),
    .load_kb (sector_count[SECT_W-1:1]),
    .step_en (shift_phase),
    .kb      (kb),
    .exp_cnt (exp_cnt),
    .fits    (kb_fits)
  );

  csd_word_merge #(
    .HB_W(HB_W), .KB_W(KB_W), .EXP_W(EXP_W)
  ) u_merge (
    .hc_sel  (hc_r),
    .blocks  (blocks_r),
    .kb      (kb),
    .exp_cnt (exp_cnt),
    .words   (merged),
    .err     (merged_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hc_r      <= 1'b0;
      blocks_r  <= '0;
      done_r    <= 1'b0;
      hc_flag_r <= 1'b0;
      err_r     <= CAP_OK;
      words_r   <= '0;
    end else begin
      done_r <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            hc_r     <= is_hc;
            blocks_r <= sector_count[SECT_W-1:10];
            st       <= is_hc ? ST_FIN : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (kb_fits) st <= ST_FIN;
        end
        ST_FIN: begin
          words_r   <= merged;
          err_r     <= merged_err;
          hc_flag_r <= hc_r;
          done_r    <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st != ST_IDLE);
  assign done    = done_r;
  assign hc_flag = hc_flag_r;
  assign err     = err_r;
  assign resp_w0 = words_r.w0;
  assign resp_w1 = words_r.w1;
  assign resp_w2 = words_r.w2;
  assign resp_w3 = words_r.w3;

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the end of a busy period coincides with done
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: results hold outside the done cycle
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({resp_w3, resp_w2, resp_w1, resp_w0, err, hc_flag}));

  // R4 / R6: an error result carries all-zero words
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err != 2'b00)) |-> ((resp_w3 | resp_w2 | resp_w1 | resp_w0) == 32'd0));

  // R8: a start during a run does not disturb the captured size
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(blocks_r));

  // R5: the standard path only finishes once the value fits
  assert_fit_at_fin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_phase && !hc_r) |-> kb_fits);

  // R2: high-capacity runs never go through the shift phase
  assert_hc_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && is_hc) |=> finish_phase);

endmodule

// File: tb/sim_csd_cap_encoder.sv
`timescale 1ns/1ps
module sim_csd_cap_encoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [33:0] sector_count = '0;
  logic        busy, done, hc_flag;
  logic [1:0]  err;
  logic [31:0] resp_w0, resp_w1, resp_w2, resp_w3;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  csd_cap_encoder u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sector_count(sector_count),
    .busy(busy), .done(done), .hc_flag(hc_flag), .err(err),
    .resp_w0(resp_w0), .resp_w1(resp_w1), .resp_w2(resp_w2), .resp_w3(resp_w3)
  );

  task automatic check(input string req, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected result from the requirement text
  task automatic predict(input logic [33:0] s, output logic [127:0] w, output logic [1:0] e,
                         output logic hc, output int lat);
    longint sl, m, kb, v;
    int n;
    sl = longint'(s);
    w = '0; e = 2'b00;
    hc = (sl > 64'd4194304);
    if (hc) begin
      lat = 1;
      m = sl / 1024 - 1;
      if (m >= 64'd4194304) e = 2'b10;
      else begin
        w[127:96] = 32'h400E0032;
        w[95:64]  = 32'h5B590000 + 32'(m / 65536);
        w[63:32]  = 32'h00007F80 + (32'(m % 65536) * 32'd65536);
        w[31:0]   = 32'h0A4040DF;
      end
    end else begin
      kb = sl / 2;
      n = 0;
      while ((kb >> n) > 4096) n++;
      lat = n + 2;
      if (n < 2) e = 2'b01;
      else if (n - 2 > 7) e = 2'b10;
      else begin
        v = (kb >> n) - 1;
        w[127:96] = 32'h00260032;
        w[95:64]  = 32'h5F5A8000 | 32'(v / 4);
        w[63:32]  = 32'h3EF84FFF | (32'(v % 4) << 30) | (32'(n - 2) << 15);
        w[31:0]   = 32'h928040CB;
      end
    end
  endtask

  // caller is at a sample point; start is raised here
  task automatic launch_wait(input logic [33:0] s, output int lat);
    sector_count = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic judge(input string req, input logic [33:0] s, input int lat);
    logic [127:0] ew; logic [1:0] ee; logic eh; int el;
    predict(s, ew, ee, eh, el);
    check("R7", "done latency", 128'(lat), 128'(el));
    check("R2", "hc_flag", 128'(hc_flag), 128'(eh));
    check(req, "err", 128'(err), 128'(ee));
    check(req, "words", {resp_w3, resp_w2, resp_w1, resp_w0}, ew);
  endtask

  task automatic run_case(input string req, input logic [33:0] s);
    int lat;
    @(negedge clk);
    launch_wait(s, lat);
    judge(req, s, lat);
  endtask

  task automatic t_reset;
    check("R1", "busy/done/hc/err", {busy, done, hc_flag, err}, 128'd0);
    check("R1", "words", {resp_w3, resp_w2, resp_w1, resp_w0}, 128'd0);
  endtask

  task automatic t_hold_after;
    logic [127:0] w0;
    int lat;
    @(negedge clk);
    launch_wait(34'd32768, lat);
    w0 = {resp_w3, resp_w2, resp_w1, resp_w0};
    @(negedge clk);
    check("R7", "done dropped", 128'(done), 128'd0);
    sector_count = 34'd12345;
    repeat (4) @(negedge clk);
    check("R9", "words held", {resp_w3, resp_w2, resp_w1, resp_w0}, w0);
  endtask

  task automatic t_busy_ignore;
    int lat;
    @(negedge clk);
    sector_count = 34'd4194304;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (2) begin @(negedge clk); lat++; end
    check("R7", "busy mid-run", 128'(busy), 128'd1);
    sector_count = 34'd16384;
    start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    judge("R8", 34'd4194304, lat);
  endtask

  task automatic t_coincide;
    int lat;
    @(negedge clk);
    launch_wait(34'd268435456, lat);
    judge("R9", 34'd268435456, lat);
    // start raised in the very cycle done is high
    launch_wait(34'd3000000, lat);
    judge("R9", 34'd3000000, lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_case("R5", 34'd32768);
    run_case("R5", 34'd16388);
    run_case("R6", 34'd16386);
    run_case("R6", 34'd16384);
    run_case("R6", 34'd0);
    run_case("R5", 34'd4194304);
    run_case("R5", 34'd3000000);
    run_case("R3", 34'd4194305);
    run_case("R3", 34'd268435456);
    run_case("R3", 34'h1_0000_03FF);
    run_case("R4", 34'h1_0000_0400);
    run_case("R4", 34'h3_FFFF_FFFF);
    t_hold_after();
    t_busy_ignore();
    t_coincide();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule